// File: doc/BRIEF.md
# Watchdog kick handover controller

This block drives the trigger line of an external supervisor watchdog. From the moment reset is released it produces its own fixed train of trigger pulses, so the supervisor stays satisfied while the host FPGA is still configuring. It also issues a short active-low reset strobe right after power-up.

The host takes over the trigger path in two steps. It first raises its enable level. It then proves it is alive by issuing a minimum number of kick pulses while that enable stays high. From then on the internal pulse train stops and every host kick reaches the trigger line. The handover cannot be undone. Dropping the enable afterwards leaves the host in charge, so the watchdog cannot be switched off again. Only a full reset returns control to the block.

All durations are given in nanoseconds and converted to clock cycles through the clock frequency parameter. The defaults give a 1 ms self-kick period with a 507 µs high phase, which fits well inside the supervisor's shortest timeout of 0.55 s. Each trigger pulse must be at least 300 ns wide.

Top module: `wdt_kick_handover`

## Requirements
- R1: While rst_ni is low, wdi_o and rst_strobe_no are both low.
- R2: Before handover, wdi_o repeats with a period of exactly PERIOD_CYC clock cycles. PERIOD_CYC is CLK_MHZ*PERIOD_NS/1000. The first rising edge of wdi_o comes at the first clock edge after reset release.
- R3: Before handover, each internal high phase of wdi_o lasts exactly HIGH_CYC cycles. HIGH_CYC is CLK_MHZ*HIGH_NS/1000.
- R4: rst_strobe_no stays low until the POR_CYC-th clock edge after reset release, where POR_CYC is CLK_MHZ*POR_NS/1000. From that edge on it stays high until the next reset.
- R5: Host kicks are counted only while the synchronised host_en_i is high. A host kick is a rising edge of host_kick_i after synchronisation. If the enable drops before handover, the count returns to zero.
- R6: Handover happens once HANDOVER_KICKS host kicks have been counted while the enable is high. One kick fewer does not trigger it. After handover the internal pulse train stops.
- R7: After handover, wdi_o stays low until the next host kick edge. From then on it follows host_kick_i, delayed by three clock edges.
- R8: Handover is sticky. Dropping host_en_i afterwards neither stops forwarding nor restarts the internal pulse train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| host_en_i | input | 1 | Host watchdog enable level, asynchronous |
| host_kick_i | input | 1 | Host kick pulse, asynchronous |
| wdi_o | output | 1 | Trigger line to the external watchdog |
| rst_strobe_no | output | 1 | Active-low power-up reset strobe |

## Verification
The bench measures the self-kick period, the high phase and the reset-strobe length to the exact cycle. An off-by-one counter shows up there as a wrong count of rising edges or high samples. It gives exactly one kick fewer than the threshold and then checks that the self pulses continue. A design that hands over too early would fall silent instead. It drops the enable partway through counting, and it also sends kicks while the enable is low. A design that keeps a stale count, or counts while disabled, would hand over too soon. After handover the bench checks that the line stays low until a fresh host edge, checks the three-edge forwarding latency, and checks that removing the enable neither revives the self-kick nor blocks forwarding.

// File: rtl/wkh_pkg.sv
package wkh_pkg;
  function automatic int ns_to_cyc(input int mhz, input int ns);
    int c;
    c = (mhz * ns) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/wkh_sync.sv
module wkh_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/wkh_self_timer.sv
module wkh_self_timer #(
  parameter int PERIOD_CYC = 100000,
  parameter int HIGH_CYC   = 50700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH = CNT_W'(HIGH_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (stop_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = !stop_i && (cnt_q < HIGH);

  // R2
  wrap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/wkh_handover.sv
module wkh_handover #(
  parameter int KICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic kick_rise_i,
  output logic handed_o
);
  localparam int KC_W = $clog2(KICKS + 1);
  localparam logic [KC_W-1:0] FULL = KC_W'(KICKS);

  logic [KC_W-1:0] cnt_q;
  logic            handed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      handed_q <= 1'b0;
    end else if (!handed_q) begin
      if (!en_i) cnt_q <= '0;
      else if (kick_rise_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      if (en_i && cnt_q == FULL) handed_q <= 1'b1;
    end
  end

  assign handed_o = handed_q;

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R5
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!handed_q && !en_i) |=> (cnt_q == '0));
  // R6
  handover_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(handed_q) |-> $past(en_i));
  // R8
  handed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handed_q |=> handed_q);
endmodule

// File: rtl/wkh_por_strobe.sv
module wkh_por_strobe #(
  parameter int POR_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_no
);
  localparam int PC_W = $clog2(POR_CYC + 1);
  localparam logic [PC_W-1:0] LAST = PC_W'(POR_CYC - 1);

  logic [PC_W-1:0] cnt_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign strobe_no = done_q;

  // R4
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_no |=> strobe_no);
endmodule

// File: rtl/wdt_kick_handover.sv
module wdt_kick_handover
  import wkh_pkg::*;
#(
  parameter int CLK_MHZ        = 100,
  parameter int PERIOD_NS      = 1_000_000,
  parameter int HIGH_NS        = 507_000,
  parameter int POR_NS         = 100_000,
  parameter int HANDOVER_KICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_en_i,
  input  logic host_kick_i,
  output logic wdi_o,
  output logic rst_strobe_no
);
  localparam int PERIOD_CYC = ns_to_cyc(CLK_MHZ, PERIOD_NS);
  localparam int HIGH_CYC   = ns_to_cyc(CLK_MHZ, HIGH_NS);
  localparam int POR_CYC    = ns_to_cyc(CLK_MHZ, POR_NS);

  logic [1:0] raw, syn;
  logic       en_s, kick_s, kick_q, kick_rise;
  logic       handed, self_pulse, armed_q, wdi_q;

  assign raw = {host_en_i, host_kick_i};

  wkh_sync #(.WIDTH(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );
  assign en_s   = syn[1];
  assign kick_s = syn[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_q <= 1'b0;
    else         kick_q <= kick_s;
  end
  assign kick_rise = kick_s && !kick_q;

  wkh_handover #(.KICKS(HANDOVER_KICKS)) u_hand (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_s),
    .kick_rise_i(kick_rise), .handed_o(handed)
  );

  wkh_self_timer #(.PERIOD_CYC(PERIOD_CYC), .HIGH_CYC(HIGH_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(handed), .pulse_o(self_pulse)
  );

  wkh_por_strobe #(.POR_CYC(POR_CYC)) u_por (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_no(rst_strobe_no)
  );

  // After handover, hold low until a fresh host edge, then follow the host.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      wdi_q   <= 1'b0;
    end else if (!handed) begin
      wdi_q <= self_pulse;
    end else begin
      if (kick_rise) armed_q <= 1'b1;
      wdi_q <= (armed_q || kick_rise) ? kick_s : 1'b0;
    end
  end

  assign wdi_o = wdi_q;

  // R6
  self_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handed && $past(handed) && !$past(kick_s)) |-> !wdi_o);
  // R7
  fwd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handed && $past(handed) && $rose(wdi_o)) |-> $past(kick_s));
  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!wdi_o && !rst_strobe_no));
endmodule

// File: tb/tb_wdt_kick_handover.sv
module tb_wdt_kick_handover;
  localparam int P = 80, H = 40, POR = 20, N = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, kick = 1'b0;
  logic wdi, strobe_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_kick_handover #(
    .CLK_MHZ(100), .PERIOD_NS(800), .HIGH_NS(400),
    .POR_NS(200), .HANDOVER_KICKS(N)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_en_i(en), .host_kick_i(kick),
    .wdi_o(wdi), .rst_strobe_no(strobe_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_kick();
    kick = 1'b1; cyc(3);
    kick = 1'b0; cyc(3);
  endtask

  task automatic observe(input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0; prev = wdi;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdi) highs++;
      if (wdi && !prev) rises++;
      prev = wdi;
    end
  endtask

  initial begin
    int first_rise, second_rise, run, lows, highs, rises;
    bit in_run, strobe_bad;
    cyc(3);
    // R1 reset state
    chk(wdi == 1'b0, "R1 wdi in reset", wdi, 0);
    chk(strobe_n == 1'b0, "R1 strobe in reset", strobe_n, 0);
    rst_n = 1'b1;

    first_rise = -1; second_rise = -1; run = 0; lows = 0; in_run = 1'b0;
    strobe_bad = 1'b0;
    for (int i = 1; i <= 170; i++) begin
      @(negedge clk);
      if (wdi && first_rise < 0) begin first_rise = i; in_run = 1'b1; end
      else if (wdi && second_rise < 0 && !in_run && first_rise > 0) second_rise = i;
      if (in_run && wdi) run++;
      if (in_run && !wdi) in_run = 1'b0;
      if (i <= 30 && !strobe_n) lows++;
      if (i >= POR && !strobe_n) strobe_bad = 1'b1;
    end
    chk(first_rise == 1, "R2 first self rise", first_rise, 1);
    chk(second_rise - first_rise == P, "R2 self period", second_rise - first_rise, P);
    chk(run == H, "R3 self high width", run, H);
    chk(lows == POR - 1, "R4 strobe low cycles", lows, POR - 1);
    chk(!strobe_bad, "R4 strobe stays high", strobe_bad, 0);

    // R6: one kick short of the threshold keeps self-kicking
    en = 1'b1; cyc(4);
    for (int k = 0; k < N - 1; k++) pulse_kick();
    observe(2 * P, highs, rises);
    chk(rises >= 2, "R6 no handover at N-1 kicks", rises, 2);

    // R5: dropping enable clears the count
    en = 1'b0; cyc(4); en = 1'b1; cyc(4);
    for (int k = 0; k < N - 1; k++) pulse_kick();
    observe(2 * P, highs, rises);
    chk(rises >= 2, "R5 count cleared by enable drop", rises, 2);

    // R5: kicks with enable low are ignored
    en = 1'b0; cyc(4);
    for (int k = 0; k < N; k++) pulse_kick();
    en = 1'b1; cyc(4);
    for (int k = 0; k < N - 1; k++) pulse_kick();
    observe(2 * P, highs, rises);
    chk(rises >= 2, "R5 kicks ignored while disabled", rises, 2);

    // R6: the N-th kick hands over and silences the self train
    pulse_kick();
    cyc(3);
    observe(2 * P, highs, rises);
    chk(highs == 0, "R6 self train stopped", highs, 0);
    chk(highs == 0, "R7 held low until fresh edge", highs, 0);

    // R7: forwarding latency of three edges
    kick = 1'b1;
    cyc(2); chk(wdi == 1'b0, "R7 not yet forwarded", wdi, 0);
    cyc(1); chk(wdi == 1'b1, "R7 forwarded rise", wdi, 1);
    cyc(4); chk(wdi == 1'b1, "R7 follows host high", wdi, 1);
    kick = 1'b0;
    cyc(2); chk(wdi == 1'b1, "R7 fall not yet forwarded", wdi, 1);
    cyc(1); chk(wdi == 1'b0, "R7 forwarded fall", wdi, 0);

    // R8: handover survives enable removal
    en = 1'b0; cyc(10);
    observe(2 * P, highs, rises);
    chk(highs == 0, "R8 no self restart", highs, 0);
    kick = 1'b1;
    cyc(3); chk(wdi == 1'b1, "R8 still forwarding", wdi, 1);
    kick = 1'b0;
    cyc(3); chk(wdi == 1'b0, "R8 forwarded fall", wdi, 0);
    chk(strobe_n == 1'b1, "R4 strobe still high", strobe_n, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule